// File: doc/BRIEF.md
# CPU Status Latch and Command Decoder

This block sits between an 8-bit processor and the system bus. At the start of every machine cycle the processor puts a status byte on its data bus and pulses an active-low status strobe. The block captures that byte when the strobe returns high. It then decodes the byte into five active-low command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge.

Read-type strobes are qualified by the processor's data-in signal. Write-type strobes are either advanced, which means they follow the captured status alone, or gated by the processor's active-low write signal. A parameter chooses between the two write modes.

The bidirectional data buffer is modelled as separate data, output-enable and input vectors on each side. A float input disconnects the system-side driver, the CPU-side driver and all commands. A hold-acknowledge input freezes read data and releases the read strobe. A strap input makes interrupt-acknowledge cycles return the all-ones restart opcode.

Top module: `cpu_status_cmd_decoder`

## Requirements
- R1: After a synchronous reset all five command outputs are 1, and the status register holds 8'hFF, which decodes to nothing. With data-in high and write low before any status is captured, no strobe asserts.
- R2: The status register loads `cpu_din` only at a clock edge where `stat_strobe_n` is sampled 1 and was sampled 0 at the previous edge. The loaded value is visible after that edge. Changes of `cpu_din` at any other time leave the decoded cycle unchanged.
- R3: Read strobes assert low only while `rd_in` is 1. `mem_rd_n` asserts for status 8'hA2, 8'h82 or 8'h86. `io_rd_n` asserts for 8'h42. `int_ack_n` asserts for 8'h23 or 8'h2B.
- R4: With ADVANCED_WR=1, `mem_wr_n` asserts low for status 8'h00 or 8'h04 and `io_wr_n` asserts low for 8'h10, whatever the level of `wr_n`.
- R5: With ADVANCED_WR=0 the same write strobes assert only while `wr_n` is also 0.
- R6: A status byte outside the nine listed values produces no strobe.
- R7: While `hold_ack` is 1 during a read, all read strobes are 1 in the same cycle. At the first clock edge with `hold_ack` and `rd_in` both 1, `sys_din` is captured. `cpu_dout` then shows the captured byte until `rd_in` falls or a new status is captured.
- R8: While `float_req` is 1, in the same cycle all commands are 1 and `cmd_oe`, `sys_doe` and `cpu_doe` are 0.
- R9: `cpu_doe` equals `rd_in` whenever `float_req` is 0. Outside restart injection and hold capture, `cpu_dout` follows `sys_din` combinationally.
- R10: With `rst7_strap` at 1, `cpu_dout` is 8'hFF while the captured status is 8'h23 or 8'h2B. For every other status it carries the system data.
- R11: For write statuses (8'h00, 8'h04, 8'h10) with `float_req` at 0, `sys_doe` is 1 and `sys_dout` carries `cpu_din`. For all other statuses `sys_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_strobe_n | input | 1 | Status strobe, low at cycle start; status is captured when it returns high |
| rd_in | input | 1 | Processor data-in: high while the processor reads |
| wr_n | input | 1 | Processor write, active low |
| hold_ack | input | 1 | Hold acknowledge |
| float_req | input | 1 | High floats all drivers and commands |
| rst7_strap | input | 1 | Enables restart-opcode injection on interrupt acknowledge |
| cpu_din | input | 8 | Byte driven by the processor (status or write data) |
| cpu_dout | output | 8 | Byte driven toward the processor |
| cpu_doe | output | 1 | Enable for the CPU-side driver |
| sys_din | input | 8 | Byte from the system bus |
| sys_dout | output | 8 | Byte driven onto the system bus |
| sys_doe | output | 1 | Enable for the system-side driver |
| cmd_oe | output | 1 | Enable for the command outputs |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| int_ack_n | output | 1 | Interrupt acknowledge strobe |

## Verification
The status register is the only state on the command path. A new status therefore takes effect one clock after the edge that sees the strobe high. Changes of `rd_in`, `wr_n`, `hold_ack`, `float_req` and the strap reach the outputs in the same cycle. The frozen hold data appears one edge after hold acknowledge is first seen with `rd_in`.

The bench changes inputs 2 ns after each rising edge and moves its reference model at the rising edge. It compares every output of both write-mode instances at the falling edge. Each result is therefore checked in exactly the cycle the requirements give for it.

// File: rtl/scd_pkg.sv
`timescale 1ns/1ps
package scd_pkg;

    parameter int DATA_W = 8;

    localparam logic [DATA_W-1:0] ST_IDLE    = 8'hFF;
    localparam logic [DATA_W-1:0] ST_FETCH   = 8'hA2;
    localparam logic [DATA_W-1:0] ST_MRD     = 8'h82;
    localparam logic [DATA_W-1:0] ST_MWR     = 8'h00;
    localparam logic [DATA_W-1:0] ST_SRD     = 8'h86;
    localparam logic [DATA_W-1:0] ST_SWR     = 8'h04;
    localparam logic [DATA_W-1:0] ST_INP     = 8'h42;
    localparam logic [DATA_W-1:0] ST_OUT     = 8'h10;
    localparam logic [DATA_W-1:0] ST_INTA    = 8'h23;
    localparam logic [DATA_W-1:0] ST_INTA_HL = 8'h2B;
    localparam logic [DATA_W-1:0] RST7_OP    = '1;

    typedef enum logic [3:0] {
        K_NONE, K_FETCH, K_MRD, K_MWR, K_SRD, K_SWR,
        K_INP, K_OUT, K_INTA, K_INTA_HL
    } kind_e;

    // Active-high internal view of the command set.
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic int_ack;
    } cmd_t;

    function automatic kind_e classify(input logic [DATA_W-1:0] st);
        case (st)
            ST_FETCH:   return K_FETCH;
            ST_MRD:     return K_MRD;
            ST_MWR:     return K_MWR;
            ST_SRD:     return K_SRD;
            ST_SWR:     return K_SWR;
            ST_INP:     return K_INP;
            ST_OUT:     return K_OUT;
            ST_INTA:    return K_INTA;
            ST_INTA_HL: return K_INTA_HL;
            default:    return K_NONE;
        endcase
    endfunction

    function automatic logic is_inta(input kind_e k);
        return (k == K_INTA) || (k == K_INTA_HL);
    endfunction

    function automatic logic is_write(input kind_e k);
        return (k == K_MWR) || (k == K_SWR) || (k == K_OUT);
    endfunction

endpackage

// File: rtl/scd_status_latch.sv
`timescale 1ns/1ps
module scd_status_latch #(
    parameter int DW = scd_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] stat_q,
    output logic          capture
);
    logic strobe_d;

    // Rising edge of the strobe as seen at the clock.
    assign capture = ~strobe_d & strobe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b1;
            stat_q   <= scd_pkg::ST_IDLE;
        end else begin
            strobe_d <= strobe_n;
            if (capture) stat_q <= din;
        end
    end
endmodule

// File: rtl/scd_cmd_gen.sv
`timescale 1ns/1ps
module scd_cmd_gen #(
    parameter bit ADVANCED_WR = 1'b1
) (
    input  scd_pkg::kind_e kind,
    input  logic           rd_in,
    input  logic           wr_n,
    input  logic           rd_block,
    input  logic           float_req,
    output scd_pkg::cmd_t  cmd
);
    import scd_pkg::*;

    logic rd_ok;
    logic wr_ok;
    logic wr_qual;

    generate
        if (ADVANCED_WR) begin : g_adv
            assign wr_qual = 1'b1;
        end else begin : g_gated
            assign wr_qual = ~wr_n;
        end
    endgenerate

    assign rd_ok = rd_in & ~rd_block & ~float_req;
    assign wr_ok = wr_qual & ~float_req;

    always_comb begin
        cmd         = '0;
        cmd.mem_rd  = rd_ok & (kind == K_FETCH || kind == K_MRD || kind == K_SRD);
        cmd.io_rd   = rd_ok & (kind == K_INP);
        cmd.int_ack = rd_ok & is_inta(kind);
        cmd.mem_wr  = wr_ok & (kind == K_MWR || kind == K_SWR);
        cmd.io_wr   = wr_ok & (kind == K_OUT);
    end
endmodule

// File: rtl/scd_data_path.sv
`timescale 1ns/1ps
module scd_data_path #(
    parameter int DW = scd_pkg::DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           capture,
    input  logic           rd_in,
    input  logic           hold_ack,
    input  logic           float_req,
    input  logic           rst7_strap,
    input  scd_pkg::kind_e kind,
    input  logic [DW-1:0]  cpu_din,
    input  logic [DW-1:0]  sys_din,
    output logic [DW-1:0]  cpu_dout,
    output logic           cpu_doe,
    output logic [DW-1:0]  sys_dout,
    output logic           sys_doe,
    output logic           rd_block
);
    import scd_pkg::*;

    logic          lock_q;
    logic [DW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            held_q <= '0;
        end else if (capture || !rd_in) begin
            lock_q <= 1'b0;
        end else if (hold_ack && !lock_q) begin
            lock_q <= 1'b1;
            held_q <= sys_din;
        end
    end

    assign rd_block = hold_ack | lock_q;
    assign cpu_doe  = rd_in & ~float_req;
    assign sys_doe  = ~float_req & is_write(kind);
    assign sys_dout = cpu_din;

    always_comb begin
        if (rst7_strap && is_inta(kind)) cpu_dout = RST7_OP;
        else if (lock_q)                 cpu_dout = held_q;
        else                             cpu_dout = sys_din;
    end
endmodule

// File: rtl/cpu_status_cmd_decoder.sv
`timescale 1ns/1ps
module cpu_status_cmd_decoder #(
    parameter bit ADVANCED_WR = 1'b1,
    parameter int DW          = scd_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stat_strobe_n,
    input  logic          rd_in,
    input  logic          wr_n,
    input  logic          hold_ack,
    input  logic          float_req,
    input  logic          rst7_strap,
    input  logic [DW-1:0] cpu_din,
    output logic [DW-1:0] cpu_dout,
    output logic          cpu_doe,
    input  logic [DW-1:0] sys_din,
    output logic [DW-1:0] sys_dout,
    output logic          sys_doe,
    output logic          cmd_oe,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          io_rd_n,
    output logic          io_wr_n,
    output logic          int_ack_n
);
    import scd_pkg::*;

    logic [DW-1:0] stat_q;
    logic          capture;
    logic          rd_block;
    kind_e         kind;
    cmd_t          cmd;

    scd_status_latch #(.DW(DW)) u_latch (
        .clk(clk), .rst(rst), .strobe_n(stat_strobe_n), .din(cpu_din),
        .stat_q(stat_q), .capture(capture)
    );

    assign kind = classify(stat_q);

    scd_data_path #(.DW(DW)) u_data (
        .clk(clk), .rst(rst), .capture(capture), .rd_in(rd_in),
        .hold_ack(hold_ack), .float_req(float_req), .rst7_strap(rst7_strap),
        .kind(kind), .cpu_din(cpu_din), .sys_din(sys_din),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .sys_dout(sys_dout),
        .sys_doe(sys_doe), .rd_block(rd_block)
    );

    scd_cmd_gen #(.ADVANCED_WR(ADVANCED_WR)) u_cmd (
        .kind(kind), .rd_in(rd_in), .wr_n(wr_n), .rd_block(rd_block),
        .float_req(float_req), .cmd(cmd)
    );

    assign cmd_oe    = ~float_req;
    assign mem_rd_n  = ~cmd.mem_rd;
    assign mem_wr_n  = ~cmd.mem_wr;
    assign io_rd_n   = ~cmd.io_rd;
    assign io_wr_n   = ~cmd.io_wr;
    assign int_ack_n = ~cmd.int_ack;
endmodule

// File: rtl/scd_checker.sv
`timescale 1ns/1ps
module scd_checker #(
    parameter bit ADVANCED_WR = 1'b1,
    parameter int DW          = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          stat_strobe_n,
    input logic          rd_in,
    input logic          wr_n,
    input logic          hold_ack,
    input logic          float_req,
    input logic [DW-1:0] cpu_din,
    input logic [DW-1:0] stat_q,
    input logic          cpu_doe,
    input logic          sys_doe,
    input logic          cmd_oe,
    input logic          mem_rd_n,
    input logic          mem_wr_n,
    input logic          io_rd_n,
    input logic          io_wr_n,
    input logic          int_ack_n
);
    logic [4:0] act;
    assign act = ~{mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n};

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> act == 5'b0);

    p_load_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stat_strobe_n) && stat_strobe_n) |=> stat_q == $past(cpu_din));

    p_hold_still_r2: assert property (@(posedge clk) disable iff (rst)
        (!stat_strobe_n || $past(stat_strobe_n)) |=> $stable(stat_q));

    p_single_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act));

    p_reads_need_rd_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_in |-> (mem_rd_n && io_rd_n && int_ack_n && !cpu_doe));

    p_gated_write_r5: assert property (@(posedge clk) disable iff (rst)
        (!ADVANCED_WR && wr_n) |-> (mem_wr_n && io_wr_n));

    p_hold_release_r7: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (mem_rd_n && io_rd_n && int_ack_n));

    p_float_all_r8: assert property (@(posedge clk) disable iff (rst)
        float_req |-> (act == 5'b0 && !cmd_oe && !sys_doe && !cpu_doe));
endmodule

bind cpu_status_cmd_decoder scd_checker #(.ADVANCED_WR(ADVANCED_WR), .DW(DW)) u_scd_checker (
    .clk(clk), .rst(rst), .stat_strobe_n(stat_strobe_n), .rd_in(rd_in),
    .wr_n(wr_n), .hold_ack(hold_ack), .float_req(float_req), .cpu_din(cpu_din),
    .stat_q(stat_q), .cpu_doe(cpu_doe), .sys_doe(sys_doe), .cmd_oe(cmd_oe),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .int_ack_n(int_ack_n)
);

// File: tb/cpu_status_cmd_decoder_bench.sv
`timescale 1ns/1ps
module cpu_status_cmd_decoder_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, stb_n, rd_in, wr_n, hold_ack, float_req, strap;
    logic [7:0] cpu_din, sys_din;

    logic [7:0] a_cdo, a_sdo, g_cdo, g_sdo;
    logic a_cdoe, a_sdoe, a_coe, a_mr, a_mw, a_ir, a_iw, a_ia;
    logic g_cdoe, g_sdoe, g_coe, g_mr, g_mw, g_ir, g_iw, g_ia;

    cpu_status_cmd_decoder #(.ADVANCED_WR(1'b1)) u_cpu_status_cmd_decoder (
        .clk(clk), .rst(rst), .stat_strobe_n(stb_n), .rd_in(rd_in), .wr_n(wr_n),
        .hold_ack(hold_ack), .float_req(float_req), .rst7_strap(strap),
        .cpu_din(cpu_din), .cpu_dout(a_cdo), .cpu_doe(a_cdoe), .sys_din(sys_din),
        .sys_dout(a_sdo), .sys_doe(a_sdoe), .cmd_oe(a_coe), .mem_rd_n(a_mr),
        .mem_wr_n(a_mw), .io_rd_n(a_ir), .io_wr_n(a_iw), .int_ack_n(a_ia));

    cpu_status_cmd_decoder #(.ADVANCED_WR(1'b0)) u_cpu_status_cmd_decoder_gt (
        .clk(clk), .rst(rst), .stat_strobe_n(stb_n), .rd_in(rd_in), .wr_n(wr_n),
        .hold_ack(hold_ack), .float_req(float_req), .rst7_strap(strap),
        .cpu_din(cpu_din), .cpu_dout(g_cdo), .cpu_doe(g_cdoe), .sys_din(sys_din),
        .sys_dout(g_sdo), .sys_doe(g_sdoe), .cmd_oe(g_coe), .mem_rd_n(g_mr),
        .mem_wr_n(g_mw), .io_rd_n(g_ir), .io_wr_n(g_iw), .int_ack_n(g_ia));

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state.
    logic [7:0] m_stat = 8'hFF;
    logic [7:0] m_held = 8'h00;
    bit m_prev = 1'b1;
    bit m_lock = 1'b0;

    function automatic int kind_of(input logic [7:0] s);
        case (s)
            8'hA2: return 1;  8'h82: return 2;  8'h00: return 3;
            8'h86: return 4;  8'h04: return 5;  8'h42: return 6;
            8'h10: return 7;  8'h23: return 8;  8'h2B: return 10;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stat = 8'hFF; m_prev = 1'b1; m_lock = 1'b0; m_held = 8'h00;
        end else begin
            if (!m_prev && stb_n) begin
                m_stat = cpu_din;
                m_lock = 1'b0;
            end else if (!rd_in) begin
                m_lock = 1'b0;
            end else if (hold_ack && !m_lock) begin
                m_lock = 1'b1;
                m_held = sys_din;
            end
            m_prev = stb_n;
        end
    end

    task automatic cmp(input string dut, input string sig, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s %s act=%h exp=%h t=%0t", cur_req, dut, sig, act, exp, $time);
        end
    endtask

    task automatic check_one(input bit adv, input string dut,
                             input logic mr, input logic mw, input logic ir, input logic iw, input logic ia,
                             input logic coe, input logic cdoe, input logic sdoe,
                             input logic [7:0] cdo, input logic [7:0] sdo);
        int k;
        bit rdok, wok, is_wr, is_ia;
        logic [7:0] exp_cdo;
        k     = kind_of(m_stat);
        rdok  = rd_in && !hold_ack && !m_lock && !float_req;
        wok   = !float_req && (adv || !wr_n);
        is_wr = (k == 3) || (k == 5) || (k == 7);
        is_ia = (k == 8) || (k == 10);
        if (strap && is_ia) exp_cdo = 8'hFF;
        else if (m_lock)    exp_cdo = m_held;
        else                exp_cdo = sys_din;
        cmp(dut, "mem_rd_n",  {7'd0, mr}, {7'd0, !(rdok && (k == 1 || k == 2 || k == 4))});
        cmp(dut, "io_rd_n",   {7'd0, ir}, {7'd0, !(rdok && k == 6)});
        cmp(dut, "int_ack_n", {7'd0, ia}, {7'd0, !(rdok && is_ia)});
        cmp(dut, "mem_wr_n",  {7'd0, mw}, {7'd0, !(wok && (k == 3 || k == 5))});
        cmp(dut, "io_wr_n",   {7'd0, iw}, {7'd0, !(wok && k == 7)});
        cmp(dut, "cmd_oe",    {7'd0, coe},  {7'd0, !float_req});
        cmp(dut, "cpu_doe",   {7'd0, cdoe}, {7'd0, rd_in && !float_req});
        cmp(dut, "sys_doe",   {7'd0, sdoe}, {7'd0, !float_req && is_wr});
        cmp(dut, "cpu_dout",  cdo, exp_cdo);
        cmp(dut, "sys_dout",  sdo, cpu_din);
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check_one(1'b1, "adv", a_mr, a_mw, a_ir, a_iw, a_ia, a_coe, a_cdoe, a_sdoe, a_cdo, a_sdo);
            check_one(1'b0, "gated", g_mr, g_mw, g_ir, g_iw, g_ia, g_coe, g_cdoe, g_sdoe, g_cdo, g_sdo);
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic strobe_status(input logic [7:0] st);
        cpu_din = st;
        stb_n = 1'b0;
        step();
        stb_n = 1'b1;
        step();
    endtask

    // One machine cycle: read cycles raise rd_in, writes hold wr_n high then low.
    task automatic bus_cycle(input logic [7:0] st, input bit is_rd, input logic [7:0] dat);
        strobe_status(st);
        if (is_rd) begin
            cpu_din = 8'h5A;
            rd_in = 1'b1;
            for (int i = 0; i < 3; i++) begin
                sys_din = dat + 8'(i);
                step();
            end
            rd_in = 1'b0;
        end else begin
            cpu_din = dat;
            step();
            wr_n = 1'b0;
            step();
            cpu_din = dat ^ 8'hFF;
            step();
            wr_n = 1'b1;
        end
        step();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; stb_n = 1'b1; rd_in = 1'b0; wr_n = 1'b1; hold_ack = 1'b0;
        float_req = 1'b0; strap = 1'b0; cpu_din = 8'h00; sys_din = 8'h00;
        step(3);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R1: nothing decodes before any status arrives.
        cur_req = "R1";
        step();
        rd_in = 1'b1; wr_n = 1'b0; sys_din = 8'h3C;
        step(2);
        rd_in = 1'b0; wr_n = 1'b1;
        step();

        // R3: every read-type status.
        cur_req = "R3";
        bus_cycle(8'hA2, 1'b1, 8'h11);
        bus_cycle(8'h82, 1'b1, 8'h22);
        bus_cycle(8'h86, 1'b1, 8'h33);
        bus_cycle(8'h42, 1'b1, 8'h44);
        bus_cycle(8'h23, 1'b1, 8'h55);
        bus_cycle(8'h2B, 1'b1, 8'h66);

        // R4 and R5: write types, wr_n high then low, both instances.
        cur_req = "R4";
        bus_cycle(8'h00, 1'b0, 8'h77);
        bus_cycle(8'h04, 1'b0, 8'h88);
        cur_req = "R5";
        bus_cycle(8'h10, 1'b0, 8'h99);
        bus_cycle(8'h00, 1'b0, 8'hA5);

        // R11: write data toward the system bus, plus a read that must not drive it.
        cur_req = "R11";
        bus_cycle(8'h04, 1'b0, 8'hC3);
        bus_cycle(8'h82, 1'b1, 8'hE0);

        // R6: unknown status bytes.
        cur_req = "R6";
        bus_cycle(8'h55, 1'b1, 8'h12);
        bus_cycle(8'h01, 1'b0, 8'h34);

        // R2: strobe held low does not load; cpu_din noise after capture ignored.
        cur_req = "R2";
        cpu_din = 8'h42; stb_n = 1'b0;
        step(3);
        cpu_din = 8'h10;
        step();
        stb_n = 1'b1;
        step();
        cpu_din = 8'h82; rd_in = 1'b1;
        step(2);
        cpu_din = 8'h23;
        step(2);
        rd_in = 1'b0;
        step();

        // R7: hold acknowledge arrives mid-read.
        cur_req = "R7";
        strobe_status(8'h82);
        rd_in = 1'b1; sys_din = 8'h61;
        step();
        hold_ack = 1'b1; sys_din = 8'h62;
        step();
        sys_din = 8'h63;
        step();
        hold_ack = 1'b0; sys_din = 8'h64;
        step(2);
        rd_in = 1'b0;
        step();
        strobe_status(8'h42);
        rd_in = 1'b1; hold_ack = 1'b1; sys_din = 8'h70;
        step();
        sys_din = 8'h71;
        step();
        rd_in = 1'b0; hold_ack = 1'b0;
        step();

        // R8: float toggled mid-read and mid-write.
        cur_req = "R8";
        strobe_status(8'h86);
        rd_in = 1'b1; sys_din = 8'h2D;
        step();
        float_req = 1'b1;
        step(2);
        float_req = 1'b0;
        step();
        rd_in = 1'b0;
        strobe_status(8'h10);
        cpu_din = 8'hD1; wr_n = 1'b0;
        step();
        float_req = 1'b1;
        step(2);
        float_req = 1'b0;
        step();
        wr_n = 1'b1;
        step();

        // R9: read data follows system data.
        cur_req = "R9";
        strobe_status(8'hA2);
        rd_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sys_din = 8'(8'h0F << (i % 4)) ^ 8'(i);
            step();
        end
        rd_in = 1'b0;
        step();

        // R10: restart injection only on interrupt acknowledge.
        cur_req = "R10";
        strap = 1'b1;
        bus_cycle(8'h23, 1'b1, 8'h01);
        bus_cycle(8'h2B, 1'b1, 8'h02);
        bus_cycle(8'h82, 1'b1, 8'h03);
        bus_cycle(8'h42, 1'b1, 8'h04);
        bus_cycle(8'h10, 1'b0, 8'h05);
        strap = 1'b0;
        bus_cycle(8'h23, 1'b1, 8'h06);

        step(2);
        cmp_en = 1'b0;
        finish_run();
    end
endmodule